// File: doc/BRIEF.md
# Synchronised Video Clock Output Divider

This block takes the fundamental video sample clock and produces a set of clock outputs, three by default. Software sets each output on its own to run at the fundamental rate, half of it or a quarter of it. Every output is built as a registered waveform in the block's own clock domain. That clock `clk` runs at twice the fundamental rate, so one `clk` cycle is one half-period of a fundamental-rate output. Because every output comes from a register, no change of setting can glitch it.

Divided outputs are re-phased to the horizontal sync signal. On the falling edge of `hsync_in`, every lane restarts its count and drives its output high. Any divide setting written since the previous edge takes effect at that moment, so a setting change never produces a runt pulse. A six-bit video standard code turns the outputs on and off. The code is taken from the `std_pins` input or from a host register, and an override bit in a control register picks which one. A code of zero parks every output low and drops the enable of the last output, which stands in for a high-impedance pad.

Registers are written through a simple port with an address, data and a write strobe. A separate read port returns the stored values combinationally.

Top module: `vclk_div_sync`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit is 0 and `clk_out_last_oe` is 0. After reset, every register reads 0, the pins are the code source and each lane is set to the fundamental rate.
- R2: The divide register of lane i sits at address 0x2C+i, and bits [1:0] select the rate: 00 gives the fundamental, 01 gives half, 10 gives a quarter and 11 gives the fundamental. Each register keeps all 8 written bits, and a read at its address returns the last value written.
- R3: A lane running at the fundamental rate inverts its output on every `clk` edge.
- R4: A lane at half rate inverts its output every 2 `clk` cycles. A lane at quarter rate inverts its output every 4 `clk` cycles.
- R5: A value written to a divide register leaves the lane's rate unchanged until the next realignment described in R6.
- R6: A realignment happens when one rising `clk` edge samples `hsync_in` high and the next edge samples it low. At the edge after that, each enabled lane loads its divide setting, drives its output to 1 and restarts its count. The first inversion then follows one half-period later.
- R7: The control register is at address 0x20, and its bit 1 picks the code source. When the bit is 1, the code is bits [5:0] of the standard register at 0x21. When it is 0, the code comes from `std_pins`.
- R8: While the selected code is zero, every `clk_out` bit is 0 and `clk_out_last_oe` is 0 from the next `clk` edge. While the code is non-zero, `clk_out_last_oe` is 1 from the next edge. A lane that leaves the disabled state restarts from output 0 with its count cleared.
- R9: A read of any address outside 0x20, 0x21 and 0x2C to 0x2E returns 0, and a write to such an address changes nothing.
- R10: While the override bit is 1, changes on `std_pins` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the fundamental rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync; its falling edge realigns the lanes |
| std_pins | input | 6 | Video standard code from the pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Stored value at `rd_addr` (combinational) |
| clk_out | output | 3 | Lane output waveforms, bit i is lane i |
| clk_out_last_oe | output | 1 | Output enable of the last lane |

## Verification
The bench builds the block with its default parameters: three lanes, 8-bit addresses and data, and the control, standard and divide registers at 0x20, 0x21 and 0x2C. With three lanes, one run can set each lane to a different rate, including the spare code 11, and check that a single sync falling edge realigns all of them together. The fixed addresses also make it possible to read back every mapped register and one unmapped address, and to move the code source between the pins and the register while the outputs are running.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  typedef enum logic [1:0] {
    RATE_FULL    = 2'b00,
    RATE_HALF    = 2'b01,
    RATE_QUARTER = 2'b10,
    RATE_SPARE   = 2'b11
  } rate_sel_e;

  localparam int unsigned MAX_HALF = 4;

  // half-period of a lane output in clk cycles
  function automatic int unsigned half_of(input rate_sel_e r);
    case (r)
      RATE_HALF:    half_of = 2;
      RATE_QUARTER: half_of = 4;
      default:      half_of = 1;
    endcase
  endfunction
endpackage

// File: rtl/vcd_regs.sv
module vcd_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_OUT   = 3,
  parameter logic [7:0]  DIV_BASE  = 8'h2C,
  parameter logic [7:0]  CTRL_ADDR = 8'h20,
  parameter logic [7:0]  STD_ADDR  = 8'h21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [DATA_W-1:0]       ctrl_q,
  output logic [DATA_W-1:0]       std_q,
  output logic [NUM_OUT-1:0][1:0] rate_q
);
  logic [DATA_W-1:0] div_r [NUM_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      std_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data;
      if (wr_addr == ADDR_W'(STD_ADDR))  std_q  <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_r[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(DIV_BASE) + ADDR_W'(g))
        div_r[g] <= wr_data;
    end
    assign rate_q[g] = div_r[g][1:0];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl_q;
    if (rd_addr == ADDR_W'(STD_ADDR))  rd_data = std_q;
    for (int i = 0; i < NUM_OUT; i++)
      if (rd_addr == ADDR_W'(DIV_BASE) + ADDR_W'(i)) rd_data = div_r[i];
  end
endmodule

// File: rtl/vcd_hs_edge.sv
module vcd_hs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_in,
  output logic fall
);
  logic hs_d1, hs_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d1 <= 1'b0;
      hs_d2 <= 1'b0;
    end else begin
      hs_d1 <= hs_in;
      hs_d2 <= hs_d1;
    end
  end

  assign fall = hs_d2 & ~hs_d1;
endmodule

// File: rtl/vcd_lane.sv
module vcd_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       realign,
  input  logic [1:0] rate_cfg,
  output logic       clk_o
);
  localparam int unsigned CNT_W = $clog2(vcd_pkg::MAX_HALF);

  vcd_pkg::rate_sel_e act;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   last;

  always_comb last = CNT_W'(vcd_pkg::half_of(act) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= vcd_pkg::RATE_FULL;
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      clk_o <= 1'b0;
    end else if (realign) begin
      act   <= vcd_pkg::rate_sel_e'(rate_cfg);
      cnt   <= '0;
      clk_o <= 1'b1;
    end else if (cnt == last) begin
      cnt   <= '0;
      clk_o <= ~clk_o;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vclk_div_sync.sv
module vclk_div_sync #(
  parameter int unsigned NUM_OUT   = 3,
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SRC_BIT   = 1,
  parameter logic [7:0]  DIV_BASE  = 8'h2C,
  parameter logic [7:0]  CTRL_ADDR = 8'h20,
  parameter logic [7:0]  STD_ADDR  = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_in,
  input  logic [CODE_W-1:0]  std_pins,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               clk_out_last_oe
);
  logic [DATA_W-1:0]       ctrl_q, std_q;
  logic [NUM_OUT-1:0][1:0] rate_q;
  logic [CODE_W-1:0]       code_sel;
  logic                    enable, hs_fall;

  vcd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT),
    .DIV_BASE(DIV_BASE), .CTRL_ADDR(CTRL_ADDR), .STD_ADDR(STD_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .std_q(std_q), .rate_q(rate_q)
  );

  vcd_hs_edge u_hs (.clk(clk), .rst_n(rst_n), .hs_in(hsync_in), .fall(hs_fall));

  assign code_sel = ctrl_q[SRC_BIT] ? std_q[CODE_W-1:0] : std_pins;
  assign enable   = |code_sel;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    vcd_lane u_lane (
      .clk(clk), .rst_n(rst_n), .enable(enable), .realign(hs_fall),
      .rate_cfg(rate_q[g]), .clk_o(clk_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out_last_oe <= 1'b0;
    else        clk_out_last_oe <= enable;
  end
endmodule

// File: rtl/vclk_div_sync_chk.sv
module vclk_div_sync_chk #(
  parameter int unsigned NUM_OUT   = 3,
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  DIV_BASE  = 8'h2C,
  parameter logic [7:0]  CTRL_ADDR = 8'h20,
  parameter logic [7:0]  STD_ADDR  = 8'h21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync_in,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NUM_OUT-1:0] clk_out,
  input logic               clk_out_last_oe,
  input logic [CODE_W-1:0]  code_sel
);
  logic h1, h2, wr_mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= 1'b0;
      h2 <= 1'b0;
    end else begin
      h1 <= hsync_in;
      h2 <= h1;
    end
  end

  always_comb begin
    wr_mapped = (wr_addr == ADDR_W'(CTRL_ADDR)) || (wr_addr == ADDR_W'(STD_ADDR));
    for (int i = 0; i < NUM_OUT; i++)
      if (wr_addr == ADDR_W'(DIV_BASE) + ADDR_W'(i)) wr_mapped = 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (clk_out == '0 && !clk_out_last_oe));

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mapped && rd_addr == wr_addr) |=>
      ($stable(rd_addr) -> rd_data == $past(wr_data)));

  assert_realign_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h2 && !h1 && code_sel != '0) |=> (clk_out == '1));

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_sel == '0) |=> (clk_out == '0 && !clk_out_last_oe));

  assert_enabled_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_sel != '0) |=> clk_out_last_oe);

  assert_oe_parks_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_last_oe |-> !clk_out[NUM_OUT-1]);
endmodule

bind vclk_div_sync vclk_div_sync_chk #(
  .NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .DIV_BASE(DIV_BASE), .CTRL_ADDR(CTRL_ADDR), .STD_ADDR(STD_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
  .clk_out(clk_out), .clk_out_last_oe(clk_out_last_oe), .code_sel(code_sel)
);

// File: tb/vclk_div_sync_tb.sv
module vclk_div_sync_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic [5:0] std_pins = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] clk_out;
  logic       clk_out_last_oe;

  int checks = 0, failures = 0;
  bit done = 0, chk_on = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  vclk_div_sync u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .std_pins(std_pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_out(clk_out), .clk_out_last_oe(clk_out_last_oe)
  );

  // behavioural reference model
  int m_ctrl, m_std, m_div[3], m_out[3], m_cnt[3], m_act[3], m_h1, m_h2, m_oe;

  function automatic int half(input int d);
    return (d == 1) ? 2 : (d == 2) ? 4 : 1;
  endfunction

  function automatic int m_read(input int a);
    if (a == 'h20) return m_ctrl;
    if (a == 'h21) return m_std;
    if (a >= 'h2C && a <= 'h2E) return m_div[a - 'h2C];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_std = 0; m_h1 = 0; m_h2 = 0; m_oe = 0;
      for (int i = 0; i < 3; i++) begin
        m_div[i] = 0; m_out[i] = 0; m_cnt[i] = 0; m_act[i] = 0;
      end
    end else begin
      int code;
      bit fall;
      code = ((m_ctrl >> 1) & 1) ? (m_std & 'h3F) : int'(std_pins);
      fall = (m_h2 == 1) && (m_h1 == 0);
      for (int i = 0; i < 3; i++) begin
        if (code == 0) begin
          m_out[i] = 0; m_cnt[i] = 0;
        end else if (fall) begin
          m_act[i] = m_div[i] & 3; m_cnt[i] = 0; m_out[i] = 1;
        end else if (m_cnt[i] == half(m_act[i]) - 1) begin
          m_cnt[i] = 0; m_out[i] = 1 - m_out[i];
        end else begin
          m_cnt[i]++;
        end
      end
      m_oe = (code != 0);
      m_h2 = m_h1; m_h1 = int'(hsync_in);
      if (wr_en) begin
        if (wr_addr == 8'h20) m_ctrl = int'(wr_data);
        if (wr_addr == 8'h21) m_std = int'(wr_data);
        if (wr_addr >= 8'h2C && wr_addr <= 8'h2E) m_div[wr_addr - 8'h2C] = int'(wr_data);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      logic [2:0] e_out;
      for (int i = 0; i < 3; i++) e_out[i] = m_out[i][0];
      checks++;
      if (clk_out !== e_out) begin
        failures++;
        $display("FAIL %s clk_out act=%b exp=%b t=%0t", tag, clk_out, e_out, $time);
      end
      checks++;
      if (clk_out_last_oe !== m_oe[0]) begin
        failures++;
        $display("FAIL %s last_oe act=%b exp=%b t=%0t", tag, clk_out_last_oe, m_oe[0], $time);
      end
      checks++;
      if (rd_data !== 8'(m_read(int'(rd_addr)))) begin
        failures++;
        $display("FAIL %s rd_data act=%h exp=%h t=%0t", tag, rd_data, 8'(m_read(int'(rd_addr))), $time);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a;
    step();
    wr_en = 1'b0;
    step();
  endtask

  task automatic hs_pulse(input int hi, input int lo);
    hsync_in = 1'b1; step(hi);
    hsync_in = 1'b0; step(lo);
  endtask

  initial begin
    chk_on = 1;
    tag = "R1"; step(4);
    rst_n = 1'b1; rd_addr = 8'h2C; step(3);
    tag = "R8"; std_pins = 6'h05; step(4);
    tag = "R3"; step(10);
    tag = "R2";
    wr(8'h2C, 8'hA1); wr(8'h2D, 8'h5E); wr(8'h2E, 8'h03);
    rd_addr = 8'h2D; step(2); rd_addr = 8'h2E; step(2);
    tag = "R5"; step(8);
    tag = "R6"; hs_pulse(3, 2);
    tag = "R4"; step(24);
    tag = "R5"; wr(8'h2C, 8'h02); wr(8'h2E, 8'h01); step(6);
    tag = "R6"; hs_pulse(1, 3); hs_pulse(5, 7);
    tag = "R4"; step(20);
    tag = "R8"; std_pins = 6'h00; step(6); hs_pulse(2, 4);
    std_pins = 6'h21; step(12);
    tag = "R7"; wr(8'h21, 8'hD2); std_pins = 6'h00; step(3);
    wr(8'h20, 8'h02); step(10);
    tag = "R10"; std_pins = 6'h3F; step(4); std_pins = 6'h00; step(4);
    wr(8'h21, 8'hC0); step(6); std_pins = 6'h11; step(6);
    tag = "R7"; wr(8'h20, 8'h00); step(8); hs_pulse(2, 10);
    tag = "R9"; wr(8'h44, 8'h7F); rd_addr = 8'h44; step(3);
    rd_addr = 8'h2F; step(2); rd_addr = 8'h20; step(2);
    tag = "R1"; rst_n = 1'b0; step(3); rst_n = 1'b1; rd_addr = 8'h21; step(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule